// File: doc/BRIEF.md
# Vector Segment Store Sequencer

This block stores a group of vector registers to memory as an array of records. One store has `nf` fields. Field k takes its elements from vector register `vs_first + k`. Element index i of every field belongs to record i. Each record is `nf` elements long, the fields sit in order inside it, and the records are packed back to back from a base address. So the block turns a structure-of-arrays held in registers into an array-of-structures in memory.

A store starts with a one-cycle `start` pulse while the block is idle. On that pulse the block latches the base address, the first register, the element width, the field count, the element count `vl`, the mask enable and the mask bits. It then reads the register file through a single combinational read port. For each active element it issues one 64-bit memory write with byte enables, under a valid/ready handshake. It runs through every element of field 0, then every element of field 1, and so on. Masked-off elements are skipped inside the same search and take no memory cycle. A one-cycle `done` pulse marks the end of the store.

Top module: `vseg_store_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_valid` are all low.
- R2: Field k (0 ≤ k < nf, nf = `nf_m1`+1) takes its elements from register number (`vs_first` + k) modulo 32. Element i of that register occupies register bits [i*W +: W], where W is the element width in bits.
- R3: The write for element i of field k goes to `base_addr` + (i*nf + k)*B, where B is the element size in bytes. The sum is computed modulo 2^32. The base must be aligned to B.
- R4: `elem_w` encodes B: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8. Each write enables exactly B byte lanes, starting at lane `mem_addr[2:0]`. Lane n is `mem_wdata[8n+7:8n]`. The element's least significant byte goes to the lowest enabled lane (little-endian).
- R5: With `vm` = 1 every element is active. With `vm` = 0, element index i is active in every field only when `mask_bits[i]` is 1. Inactive elements produce no write and leave memory unchanged.
- R6: Writes are issued field by field, with field 0 first. Within a field they are issued in ascending element index.
- R7: Each field covers element indices 0 to `vl`-1. With `vl` = 0 the store makes no write and still completes with `done`. `vl` must not exceed 128/W.
- R8: While `mem_valid` is high and `mem_ready` is low, the next cycle keeps `mem_valid` high with the same `mem_addr`, `mem_wdata` and `mem_be`.
- R9: `done` is high for exactly one cycle, with `busy` low, after the last write of a store. A `start` pulse while `busy` is high is ignored.
- R10: With `mem_ready` held high, `busy` stays high for exactly (number of active elements + nf) cycles. That is one cycle per write plus one cycle per field to close it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a store; sampled only while idle |
| base_addr | input | ADDR_W | Base byte address of record 0 |
| vs_first | input | REG_AW | Register that holds field 0 |
| elem_w | input | 2 | Element size code (R4) |
| nf_m1 | input | 3 | Field count minus one |
| vl | input | IW | Elements per field |
| vm | input | 1 | 1 = mask ignored, all elements active |
| mask_bits | input | NE | Per-index active bits |
| busy | output | 1 | Store in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | REG_AW | Register file read address |
| rf_rdata | input | VLEN | Register file read data (same cycle) |
| mem_valid | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Write byte address |
| mem_wdata | output | 64 | Write data, placed in lanes |
| mem_be | output | 8 | Byte enables |

## Verification
A wrong field counter shows up in the first write after that field starts: `rf_raddr` points at the wrong register and `mem_addr` lands in the wrong slot of the record. Both appear in stored bytes that differ from the expected interleaving. A wrong element index or a broken mask search shows up as a skipped or extra write, or as writes out of order, within the same field. A corrupted width code or lane shift shows up at once in the number and position of the enabled bytes, so the bytes next to an element are overwritten. An exit from the store that is one cycle early or late changes the length of `busy` and when `done` comes, so it is visible at the end of the store.

// File: rtl/vseg_store_seq.sv
module vseg_store_seq #(
  parameter int VLEN   = 128,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5,
  localparam int NE = VLEN / 8,
  localparam int IW = $clog2(NE) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [REG_AW-1:0] vs_first,
  input  logic [1:0]        elem_w,
  input  logic [2:0]        nf_m1,
  input  logic [IW-1:0]     vl,
  input  logic              vm,
  input  logic [NE-1:0]     mask_bits,
  output logic              busy,
  output logic              done,
  output logic [REG_AW-1:0] rf_raddr,
  input  logic [VLEN-1:0]   rf_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be
);

  localparam int SW = $clog2(VLEN) + 4;

  logic [ADDR_W-1:0] base_q;
  logic [REG_AW-1:0] reg_q;
  logic [1:0]        ew_q;
  logic [3:0]        nf_q;
  logic [IW-1:0]     vl_q;
  logic              vm_q;
  logic [NE-1:0]     mask_q;
  logic [2:0]        fld_q;
  logic [IW-1:0]     idx_q;

  logic              found;
  logic [IW-1:0]     cur;
  logic [SW-1:0]     bit_off;
  logic [VLEN-1:0]   elem_sh;
  logic [63:0]       wmask;
  logic [7:0]        be_base;

  always_comb begin
    found = 1'b0;
    cur   = '0;
    for (int j = 0; j < NE; j++) begin
      if (!found && IW'(j) >= idx_q && IW'(j) < vl_q && (vm_q || mask_q[j])) begin
        found = 1'b1;
        cur   = IW'(j);
      end
    end
  end

  assign rf_raddr  = reg_q + REG_AW'(fld_q);
  assign bit_off   = SW'({cur, 3'b000}) << ew_q;
  assign elem_sh   = rf_rdata >> bit_off;
  assign wmask     = (ew_q == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF
                                    : ((64'd1 << (7'd8 << ew_q)) - 64'd1);
  assign be_base   = 8'hFF >> (4'd8 - (4'd1 << ew_q));
  assign mem_valid = busy && found;
  assign mem_addr  = base_q + ((ADDR_W'(cur) * ADDR_W'(nf_q) + ADDR_W'(fld_q)) << ew_q);
  assign mem_wdata = (elem_sh[63:0] & wmask) << {mem_addr[2:0], 3'b000};
  assign mem_be    = be_base << mem_addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      base_q <= '0;
      reg_q  <= '0;
      ew_q   <= '0;
      nf_q   <= 4'd1;
      vl_q   <= '0;
      vm_q   <= 1'b0;
      mask_q <= '0;
      fld_q  <= '0;
      idx_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          base_q <= base_addr;
          reg_q  <= vs_first;
          ew_q   <= elem_w;
          nf_q   <= {1'b0, nf_m1} + 4'd1;
          vl_q   <= vl;
          vm_q   <= vm;
          mask_q <= mask_bits;
          fld_q  <= '0;
          idx_q  <= '0;
        end
      end else if (found) begin
        if (mem_ready) idx_q <= cur + IW'(1);
      end else if ({1'b0, fld_q} == nf_q - 4'd1) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        fld_q <= fld_q + 3'd1;
        idx_q <= '0;
      end
    end
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be));

  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> $countones(mem_be) == (32'd1 << ew_q));

  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (4'(mem_addr[2:0]) & ((4'd1 << ew_q) - 4'd1)) == 4'd0);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_valid);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

endmodule

// File: tb/vseg_store_seq_bench.sv
module vseg_store_seq_bench;
  localparam int CLK_NS = 10;
  localparam int VLEN = 128;
  localparam int NE = VLEN / 8;
  localparam int IW = $clog2(NE) + 1;
  localparam int MW = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [4:0] vs_first = '0;
  logic [1:0] elem_w = '0;
  logic [2:0] nf_m1 = '0;
  logic [IW-1:0] vl_i = '0;
  logic vm = 1'b1;
  logic [NE-1:0] mask_bits = '0;
  logic busy, done, mem_valid;
  logic mem_ready = 1'b1;
  logic [4:0] rf_raddr;
  logic [VLEN-1:0] rf_rdata;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0] mem_be;

  always #(CLK_NS/2) clk = ~clk;

  vseg_store_seq #(.VLEN(VLEN), .ADDR_W(32), .REG_AW(5)) u_vseg_store_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .vs_first(vs_first),
    .elem_w(elem_w), .nf_m1(nf_m1), .vl(vl_i), .vm(vm), .mask_bits(mask_bits),
    .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be));

  logic [VLEN-1:0] rf [32];
  assign rf_rdata = rf[rf_raddr];
  logic [7:0] mem [MW];

  int errors = 0, checks = 0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int wr_n = 0, busy_cyc = 0, done_cnt = 0, order_err = 0, hold_err = 0, pulse_err = 0, exp_n = 0;
  logic [31:0] exp_a [256];
  logic pv = 1'b0, pr = 1'b1, pdone = 1'b0;
  logic [31:0] pa = '0;
  logic [63:0] pd = '0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
    if (pv && !pr && !(mem_valid && mem_addr == pa && mem_wdata == pd)) hold_err++;
    if (busy) busy_cyc++;
    if (done) begin
      done_cnt++;
      if (busy || pdone) pulse_err++;
    end
    if (mem_valid && mem_ready) begin
      for (int b = 0; b < 8; b++)
        if (mem_be[b]) mem[9'(mem_addr[8:0] & 9'h1F8) + 9'(b)] = mem_wdata[8*b +: 8];
      if (wr_n >= exp_n || mem_addr != exp_a[wr_n]) order_err++;
      wr_n++;
    end
    pv = mem_valid; pr = mem_ready; pa = mem_addr; pd = mem_wdata; pdone = done;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] base, input int vs3, input int ew, input int nf, input int vl,
                     input bit vmf, input logic [NE-1:0] mk, input int rm, input bit poke);
    int eb, span, bad, t;
    eb = 1 << ew;
    span = nf * eb * vl;
    bad = 0;
    for (int m = 0; m < MW; m++) mem[m] = 8'hA5;
    @(posedge clk); #1;
    exp_n = 0;
    for (int k = 0; k < nf; k++)
      for (int i = 0; i < vl; i++)
        if (vmf || mk[i]) begin
          exp_a[exp_n] = base + 32'((i * nf + k) << ew);
          exp_n++;
        end
    wr_n = 0; busy_cyc = 0; done_cnt = 0; order_err = 0; hold_err = 0; pulse_err = 0;
    rmode = rm;
    @(negedge clk);
    start = 1'b1; base_addr = base; vs_first = 5'(vs3); elem_w = 2'(ew);
    nf_m1 = 3'(nf - 1); vl_i = IW'(vl); vm = vmf; mask_bits = mk;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; base_addr = base + 32'd64; vs_first = 5'(vs3 + 5); elem_w = 2'd0;
      nf_m1 = 3'd0; vl_i = IW'(1); vm = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (t < 3000 && done_cnt == 0) begin @(negedge clk); t++; end
    repeat (6) @(negedge clk);
    for (int o = 0; o < span + 16; o++) begin
      int rec, rem, k, b;
      logic [7:0] e;
      e = 8'hA5;
      rec = o / (nf * eb);
      if (rec < vl) begin
        rem = o % (nf * eb); k = rem / eb; b = rem % eb;
        if (vmf || mk[rec]) e = rf[(vs3 + k) % 32][(rec * eb + b) * 8 +: 8];
      end
      if (mem[9'(base + 32'(o))] != e) bad++;
    end
    chk(bad == 0, "R2 R3 R4 R5", "mismatched memory bytes", bad, 0);
    chk(wr_n == exp_n, "R5 R7", "write count", wr_n, exp_n);
    chk(order_err == 0, "R6", "out-of-order writes", order_err, 0);
    chk(hold_err == 0, "R8", "stall hold violations", hold_err, 0);
    chk(done_cnt == 1 && pulse_err == 0, "R9", "done pulses", done_cnt, 1);
    if (rm == 0) chk(busy_cyc == exp_n + nf, "R10", "busy cycles", busy_cyc, exp_n + nf);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 32; r++)
      for (int b = 0; b < NE; b++) rf[r][8*b +: 8] = 8'(r * 37 + b * 11 + 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(mem_valid == 1'b0, "R1", "mem_valid after reset", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_valid, "R1", "idle after release", int'(busy), 0);
    for (int ew = 0; ew < 4; ew++)
      for (int nf = 1; nf <= 8; nf++) begin
        int maxv;
        maxv = NE >> ew;
        run(32'h100 + 32'(nf * 8), nf * 3 + ew, ew, nf, maxv, 1'b1, '0, 1, 1'b0);
        run(32'h40 + 32'(ew * 8), 30, ew, nf, maxv - 1, 1'b0,
            NE'(16'hB36D >> (nf + ew)) | NE'(16'h8001), 0, 1'b0);
      end
    run(32'h80, 4, 1, 4, 0, 1'b1, '0, 0, 1'b0);          // R7 empty store
    run(32'hFFFF_FFF8, 9, 2, 3, 4, 1'b1, '0, 1, 1'b0);    // R3 address wrap
    run(32'h20, 2, 0, 5, 16, 1'b0, '0, 0, 1'b0);          // R5 all masked off
    run(32'h08, 12, 0, 8, 16, 1'b1, '0, 1, 1'b1);         // R9 start while busy
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule